// File: doc/BRIEF.md
# Banked Register File with Data-Memory Window

This block holds the general-purpose byte registers of a small processor core: four banks of eight 8-bit registers. Instruction datapaths reach it through bank-relative ports. There are two byte read ports and one byte write port, each addressed by a 3-bit register index. A 16-bit pair port reads or writes two neighbouring registers at once. Which bank those ports use is chosen by a 2-bit bank number. A bank-select operation loads that number, and it holds until the next load.

The same 32 bytes of storage also appear in the data address space as a window from FEE0h to FEFFh. A byte-wide memory port decodes a 16-bit address and reads or writes the register storage directly.

The window is laid out backwards by bank. Bank 0 occupies the top eight bytes and bank 3 the bottom eight. Within a bank, register 0 sits at the lowest address. Software can therefore save or inspect any bank with plain loads and stores, while instructions keep using register names.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets the active bank `cur_bank` to 0, whatever bank was active before.
- R2: When `bank_sel_we` is high at a rising edge, `cur_bank` takes `bank_sel_val`; otherwise it holds. Register-port reads and writes in a cycle use the bank held before that edge.
- R3: Each byte read port returns, without a clock, the register of the active bank picked by its 3-bit index. The index values are X=0, A=1, C=2, B=3, E=4, D=5, L=6, H=7.
- R4: With `wr_en` high, `wr_data` is stored in register `wr_idx` of the active bank at the rising edge. A read of that register in the same cycle still returns the old value.
- R5: The pair read port with index n (0..3) returns {R(2n+1), R(2n)} of the active bank. The odd register is in bits 15:8, so pair 0 is {A, X}.
- R6: With `pr_we` high, one rising edge stores `pr_wr_data[7:0]` in R(2n) and `pr_wr_data[15:8]` in R(2n+1) of the active bank, where n is `pr_wr_idx`.
- R7: `mem_hit` is high exactly when `mem_addr[15:5]` equals 7F7h, that is, for addresses FEE0h to FEFFh. Register r of bank b lives at FEE0h + 8*(3-b) + r. On a hit, `mem_rdata` returns that byte.
- R8: With `mem_we` high and a hit, `mem_wdata` is stored in the addressed byte at the rising edge. With a miss, the write changes no register and `mem_rdata` reads 0.
- R9: When several writes land on the same byte at one edge, the byte write port wins over the pair port, and the pair port wins over the memory port. Writes to different bytes at the same edge all take effect.
- R10: A write through any port changes only its target bytes. Registers of other banks, and other registers of the same bank, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the bank select |
| bank_sel_we | input | 1 | Load a new active bank |
| bank_sel_val | input | 2 | Bank number to load |
| cur_bank | output | 2 | Active bank |
| rd_a_idx | input | 3 | Register index, read port A |
| rd_a_data | output | 8 | Read data, port A |
| rd_b_idx | input | 3 | Register index, read port B |
| rd_b_data | output | 8 | Read data, port B |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 3 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pr_rd_idx | input | 2 | Pair read index |
| pr_rd_data | output | 16 | Pair read data, odd register high |
| pr_we | input | 1 | Pair write enable |
| pr_wr_idx | input | 2 | Pair write index |
| pr_wr_data | input | 16 | Pair write data |
| mem_addr | input | 16 | Data-memory byte address |
| mem_we | input | 1 | Memory-side write enable |
| mem_wdata | input | 8 | Memory-side write data |
| mem_hit | output | 1 | Address falls inside the register window |
| mem_rdata | output | 8 | Memory-side read data, 0 on a miss |

## Verification
The assertions check on every cycle the bank-select behaviour after reset, on a load and while holding. They also check that a byte write is visible on read port A in the next cycle when the index and bank still match. Two further checks hold whenever their conditions arise: the pair read agrees with the two byte reads of the same registers, and a miss reads zero. The backwards bank-to-address mapping, the write priority between the three ports, the old-value read during a write, and the absence of any effect from writes outside the window are shown only by the bench scenarios. Those scenarios compare every byte of the window against a model built from the requirements.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Geometry of the register file
    localparam int RF_BANKS = 4;
    localparam int RF_REGS  = 8;
    localparam int RF_DW    = 8;
    localparam int RF_AW    = 16;

    localparam int BANK_W   = $clog2(RF_BANKS);
    localparam int REG_W    = $clog2(RF_REGS);
    localparam int PAIR_W   = REG_W - 1;
    localparam int PHYS_W   = BANK_W + REG_W;
    localparam int PHYS_N   = RF_BANKS * RF_REGS;
    localparam int PAIR_DW  = 2 * RF_DW;

    typedef logic [RF_DW-1:0]   byte_t;
    typedef logic [PAIR_DW-1:0] word_t;
    typedef logic [BANK_W-1:0]  bank_t;
    typedef logic [REG_W-1:0]   ridx_t;
    typedef logic [PAIR_W-1:0]  pidx_t;
    typedef logic [PHYS_W-1:0]  phys_t;
    typedef logic [RF_AW-1:0]   addr_t;

    // Register names by index within a bank
    typedef enum logic [REG_W-1:0] {
        REG_X = 3'd0, REG_A = 3'd1, REG_C = 3'd2, REG_B = 3'd3,
        REG_E = 3'd4, REG_D = 3'd5, REG_L = 3'd6, REG_H = 3'd7
    } reg_name_e;

    // One-byte write request into physical storage
    typedef struct packed {
        logic  en;
        phys_t idx;
        byte_t data;
    } byte_wr_t;

    // Two-byte write request, lo_idx always even
    typedef struct packed {
        logic  en;
        phys_t lo_idx;
        word_t data;
    } pair_wr_t;

    // Physical index of a register in a bank
    function automatic phys_t phys_of(bank_t b, ridx_t r);
        return {b, r};
    endfunction

    // Physical index of the low byte of a pair in a bank
    function automatic phys_t phys_of_pair(bank_t b, pidx_t p);
        return {b, p, 1'b0};
    endfunction

    // Window offset -> physical index; bank 0 sits at the top of the window
    function automatic phys_t phys_of_offset(phys_t off);
        bank_t b;
        b = bank_t'(RF_BANKS - 1) - off[PHYS_W-1:REG_W];
        return {b, off[REG_W-1:0]};
    endfunction

endpackage

// File: rtl/rf_bank_ctrl.sv
module rf_bank_ctrl
    import regfile_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sel_we,
    input  bank_t sel_val,
    output bank_t bank
);
    bank_t bank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bank_q <= '0;
        end else if (sel_we) begin
            bank_q <= sel_val;
        end
    end

    assign bank = bank_q;
endmodule

// File: rtl/rf_win_decode.sv
module rf_win_decode
    import regfile_pkg::*;
#(
    parameter addr_t WIN_BASE = 16'hFEE0
) (
    input  addr_t addr,
    output logic  hit,
    output phys_t idx
);
    localparam int TAG_LSB = PHYS_W;

    always_comb begin
        hit = (addr[RF_AW-1:TAG_LSB] == WIN_BASE[RF_AW-1:TAG_LSB]);
        idx = phys_of_offset(addr[PHYS_W-1:0]);
    end
endmodule

// File: rtl/rf_storage.sv
module rf_storage
    import regfile_pkg::*;
#(
    parameter int NRD = 3
) (
    input  logic     clk,
    input  byte_wr_t byte_wr,
    input  pair_wr_t pair_wr,
    input  byte_wr_t mem_wr,
    input  phys_t    rd_idx  [NRD],
    output byte_t    rd_data [NRD],
    input  phys_t    pr_lo_idx,
    output word_t    pr_data
);
    byte_t store_q [PHYS_N];
    byte_t store_d [PHYS_N];

    phys_t pair_hi_idx;
    phys_t pr_hi_idx;

    assign pair_hi_idx = {pair_wr.lo_idx[PHYS_W-1:1], 1'b1};
    assign pr_hi_idx   = {pr_lo_idx[PHYS_W-1:1], 1'b1};

    // Per-byte merge: byte port, then pair port, then memory port
    always_comb begin
        for (int i = 0; i < PHYS_N; i++) begin
            if (byte_wr.en && byte_wr.idx == phys_t'(i)) begin
                store_d[i] = byte_wr.data;
            end else if (pair_wr.en && pair_wr.lo_idx == phys_t'(i)) begin
                store_d[i] = pair_wr.data[RF_DW-1:0];
            end else if (pair_wr.en && pair_hi_idx == phys_t'(i)) begin
                store_d[i] = pair_wr.data[PAIR_DW-1:RF_DW];
            end else if (mem_wr.en && mem_wr.idx == phys_t'(i)) begin
                store_d[i] = mem_wr.data;
            end else begin
                store_d[i] = store_q[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PHYS_N; i++) begin
            store_q[i] <= store_d[i];
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rd_data[g] = store_q[rd_idx[g]];
        end
    endgenerate

    assign pr_data = {store_q[pr_hi_idx], store_q[pr_lo_idx]};
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import regfile_pkg::*;
#(
    parameter addr_t WIN_BASE = 16'hFEE0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bank_sel_we,
    input  logic [BANK_W-1:0]    bank_sel_val,
    output logic [BANK_W-1:0]    cur_bank,
    input  logic [REG_W-1:0]     rd_a_idx,
    output logic [RF_DW-1:0]     rd_a_data,
    input  logic [REG_W-1:0]     rd_b_idx,
    output logic [RF_DW-1:0]     rd_b_data,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_idx,
    input  logic [RF_DW-1:0]     wr_data,
    input  logic [PAIR_W-1:0]    pr_rd_idx,
    output logic [PAIR_DW-1:0]   pr_rd_data,
    input  logic                 pr_we,
    input  logic [PAIR_W-1:0]    pr_wr_idx,
    input  logic [PAIR_DW-1:0]   pr_wr_data,
    input  logic [RF_AW-1:0]     mem_addr,
    input  logic                 mem_we,
    input  logic [RF_DW-1:0]     mem_wdata,
    output logic                 mem_hit,
    output logic [RF_DW-1:0]     mem_rdata
);
    localparam int NRD    = 3;
    localparam int RD_A   = 0;
    localparam int RD_B   = 1;
    localparam int RD_MEM = 2;

    bank_t    bank;
    logic     win_hit;
    phys_t    win_idx;
    byte_wr_t byte_req;
    pair_wr_t pair_req;
    byte_wr_t mem_req;
    phys_t    rd_idx  [NRD];
    byte_t    rd_data [NRD];
    phys_t    pr_lo;
    word_t    pr_word;

    rf_bank_ctrl u_bank (
        .clk     (clk),
        .rst     (rst),
        .sel_we  (bank_sel_we),
        .sel_val (bank_sel_val),
        .bank    (bank)
    );

    rf_win_decode #(.WIN_BASE(WIN_BASE)) u_dec (
        .addr (mem_addr),
        .hit  (win_hit),
        .idx  (win_idx)
    );

    always_comb begin
        byte_req.en      = wr_en;
        byte_req.idx     = phys_of(bank, wr_idx);
        byte_req.data    = wr_data;
        pair_req.en      = pr_we;
        pair_req.lo_idx  = phys_of_pair(bank, pr_wr_idx);
        pair_req.data    = pr_wr_data;
        mem_req.en       = mem_we & win_hit;
        mem_req.idx      = win_idx;
        mem_req.data     = mem_wdata;
    end

    assign rd_idx[RD_A]   = phys_of(bank, rd_a_idx);
    assign rd_idx[RD_B]   = phys_of(bank, rd_b_idx);
    assign rd_idx[RD_MEM] = win_idx;
    assign pr_lo          = phys_of_pair(bank, pr_rd_idx);

    rf_storage #(.NRD(NRD)) u_store (
        .clk       (clk),
        .byte_wr   (byte_req),
        .pair_wr   (pair_req),
        .mem_wr    (mem_req),
        .rd_idx    (rd_idx),
        .rd_data   (rd_data),
        .pr_lo_idx (pr_lo),
        .pr_data   (pr_word)
    );

    assign cur_bank   = bank;
    assign rd_a_data  = rd_data[RD_A];
    assign rd_b_data  = rd_data[RD_B];
    assign pr_rd_data = pr_word;
    assign mem_hit    = win_hit;
    assign mem_rdata  = win_hit ? rd_data[RD_MEM] : '0;
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import regfile_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                bank_sel_we,
    input logic [BANK_W-1:0]   bank_sel_val,
    input logic [BANK_W-1:0]   cur_bank,
    input logic                wr_en,
    input logic [REG_W-1:0]    wr_idx,
    input logic [RF_DW-1:0]    wr_data,
    input logic [REG_W-1:0]    rd_a_idx,
    input logic [RF_DW-1:0]    rd_a_data,
    input logic [REG_W-1:0]    rd_b_idx,
    input logic [RF_DW-1:0]    rd_b_data,
    input logic [PAIR_W-1:0]   pr_rd_idx,
    input logic [PAIR_DW-1:0]  pr_rd_data,
    input logic                mem_hit,
    input logic [RF_DW-1:0]    mem_rdata
);
    p_reset_bank_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cur_bank == '0);

    p_bank_load_r2: assert property (@(posedge clk) disable iff (rst)
        bank_sel_we |=> cur_bank == $past(bank_sel_val));

    p_bank_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !bank_sel_we |=> $stable(cur_bank));

    p_write_visible_r4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_a_idx != $past(wr_idx) || cur_bank != $past(cur_bank)
                   || rd_a_data == $past(wr_data)));

    p_pair_matches_bytes_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == {pr_rd_idx, 1'b0} && rd_b_idx == {pr_rd_idx, 1'b1})
        |-> pr_rd_data == {rd_b_data, rd_a_data});

    p_miss_reads_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !mem_hit |-> mem_rdata == '0);
endmodule

bind banked_regfile banked_regfile_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .bank_sel_we  (bank_sel_we),
    .bank_sel_val (bank_sel_val),
    .cur_bank     (cur_bank),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .rd_b_idx     (rd_b_idx),
    .rd_b_data    (rd_b_data),
    .pr_rd_idx    (pr_rd_idx),
    .pr_rd_data   (pr_rd_data),
    .mem_hit      (mem_hit),
    .mem_rdata    (mem_rdata)
);

// File: tb/banked_regfile_tb.sv
`timescale 1ns/1ps
module banked_regfile_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bank_sel_we = 1'b0;
    logic [1:0]  bank_sel_val = '0;
    logic [1:0]  cur_bank;
    logic [2:0]  rd_a_idx = '0;
    logic [7:0]  rd_a_data;
    logic [2:0]  rd_b_idx = '0;
    logic [7:0]  rd_b_data;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [7:0]  wr_data = '0;
    logic [1:0]  pr_rd_idx = '0;
    logic [15:0] pr_rd_data;
    logic        pr_we = 1'b0;
    logic [1:0]  pr_wr_idx = '0;
    logic [15:0] pr_wr_data = '0;
    logic [15:0] mem_addr = '0;
    logic        mem_we = 1'b0;
    logic [7:0]  mem_wdata = '0;
    logic        mem_hit;
    logic [7:0]  mem_rdata;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;
    logic [7:0] model [4][8];
    logic [1:0] mbank = '0;

    always #4 clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst(rst), .bank_sel_we(bank_sel_we), .bank_sel_val(bank_sel_val),
        .cur_bank(cur_bank), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .pr_rd_idx(pr_rd_idx), .pr_rd_data(pr_rd_data),
        .pr_we(pr_we), .pr_wr_idx(pr_wr_idx), .pr_wr_data(pr_wr_data),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
        .mem_hit(mem_hit), .mem_rdata(mem_rdata)
    );

    function automatic logic [15:0] addr_of(logic [1:0] b, logic [2:0] r);
        return 16'hFEE0 + 16'(8 * (3 - int'(b))) + 16'(r);
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive for one edge, then release at the next falling edge
    task automatic wr_byte(logic [2:0] idx, logic [7:0] d);
        wr_en = 1'b1; wr_idx = idx; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[mbank][idx] = d;
    endtask

    task automatic mem_write(logic [15:0] a, logic [7:0] d);
        mem_we = 1'b1; mem_addr = a; mem_wdata = d;
        @(negedge clk);
        mem_we = 1'b0;
    endtask

    task automatic sel_bank(logic [1:0] b);
        bank_sel_we = 1'b1; bank_sel_val = b;
        @(negedge clk);
        bank_sel_we = 1'b0;
        mbank = b;
    endtask

    task automatic sweep_mem(string req);
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) begin
                mem_addr = addr_of(2'(b), 3'(r));
                #1;
                chk(req, $sformatf("window byte b%0d r%0d", b, r), 16'(mem_rdata), 16'(model[b][r]));
            end
        end
    endtask

    task automatic t_reset;
        chk("R1", "bank after reset", 16'(cur_bank), 16'd0);
        sel_bank(2'd3);
        chk("R2", "bank after select", 16'(cur_bank), 16'd3);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        mbank = 2'd0;
        chk("R1", "bank after mid-run reset", 16'(cur_bank), 16'd0);
    endtask

    task automatic t_fill_by_mem;
        for (int b = 0; b < 4; b++) begin
            for (int r = 0; r < 8; r++) begin
                mem_write(addr_of(2'(b), 3'(r)), 8'(16 * b + r + 8'h40));
                model[b][r] = 8'(16 * b + r + 8'h40);
            end
        end
        sweep_mem("R8");
        // bank 2 register L seen through the named ports
        sel_bank(2'd2);
        rd_a_idx = 3'd6; rd_b_idx = 3'd0; #1;
        chk("R7", "bank2 L via port A", 16'(rd_a_data), 16'(model[2][6]));
        chk("R3", "bank2 X via port B", 16'(rd_b_data), 16'(model[2][0]));
    endtask

    task automatic t_byte_rw;
        sel_bank(2'd0);
        for (int r = 0; r < 8; r++) wr_byte(3'(r), 8'(8'hA0 + r));
        for (int r = 0; r < 8; r++) begin
            rd_a_idx = 3'(r); rd_b_idx = 3'(7 - r); #1;
            chk("R3", "port A read", 16'(rd_a_data), 16'(model[0][r]));
            chk("R3", "port B read", 16'(rd_b_data), 16'(model[0][7 - r]));
        end
        // same-cycle read sees old value
        rd_a_idx = 3'd1;
        wr_en = 1'b1; wr_idx = 3'd1; wr_data = 8'h5C; #1;
        chk("R4", "read during write returns old", 16'(rd_a_data), 16'(model[0][1]));
        @(negedge clk);
        wr_en = 1'b0;
        model[0][1] = 8'h5C;
        #1;
        chk("R4", "read after write", 16'(rd_a_data), 16'h5C);
        sweep_mem("R10");
    endtask

    task automatic t_pair;
        sel_bank(2'd1);
        pr_we = 1'b1; pr_wr_idx = 2'd2; pr_wr_data = 16'hBEEF;
        @(negedge clk);
        pr_we = 1'b0;
        model[1][4] = 8'hEF; model[1][5] = 8'hBE;
        rd_a_idx = 3'd4; rd_b_idx = 3'd5; #1;
        chk("R6", "pair low byte to E", 16'(rd_a_data), 16'hEF);
        chk("R6", "pair high byte to D", 16'(rd_b_data), 16'hBE);
        for (int p = 0; p < 4; p++) begin
            pr_rd_idx = 2'(p); #1;
            chk("R5", $sformatf("pair read %0d", p), pr_rd_data,
                {model[1][2 * p + 1], model[1][2 * p]});
        end
        sweep_mem("R10");
    endtask

    task automatic t_window;
        mem_addr = 16'hFEE0; #1;
        chk("R7", "hit at FEE0", 16'(mem_hit), 16'd1);
        mem_addr = 16'hFEFF; #1;
        chk("R7", "hit at FEFF", 16'(mem_hit), 16'd1);
        chk("R7", "FEFF is bank0 H", 16'(mem_rdata), 16'(model[0][7]));
        mem_addr = 16'hFEDF; #1;
        chk("R7", "miss at FEDF", 16'(mem_hit), 16'd0);
        chk("R8", "miss reads zero", 16'(mem_rdata), 16'd0);
        mem_addr = 16'hFF00; #1;
        chk("R7", "miss at FF00", 16'(mem_hit), 16'd0);
        mem_addr = 16'h7EF9; #1;
        chk("R7", "miss at 7EF9", 16'(mem_hit), 16'd0);
        // writes outside the window change nothing
        mem_write(16'h7EF9, 8'hEE);
        mem_write(16'hFF01, 8'hEE);
        mem_write(16'hFEDF, 8'hEE);
        sweep_mem("R8");
        // window write seen through named port of bank 0
        sel_bank(2'd0);
        mem_write(16'hFEF9, 8'h3D);
        model[0][1] = 8'h3D;
        rd_a_idx = 3'd1; #1;
        chk("R8", "window write to bank0 A", 16'(rd_a_data), 16'h3D);
    endtask

    task automatic t_priority;
        sel_bank(2'd3);
        wr_en = 1'b1; wr_idx = 3'd4; wr_data = 8'h11;
        pr_we = 1'b1; pr_wr_idx = 2'd2; pr_wr_data = 16'h2233;
        mem_we = 1'b1; mem_addr = addr_of(2'd3, 3'd4); mem_wdata = 8'h44;
        @(negedge clk);
        model[3][4] = 8'h11; model[3][5] = 8'h22;
        wr_idx = 3'd1; wr_data = 8'h66;
        pr_wr_idx = 2'd3; pr_wr_data = 16'h5566;
        mem_addr = addr_of(2'd3, 3'd7); mem_wdata = 8'h77;
        @(negedge clk);
        model[3][1] = 8'h66; model[3][6] = 8'h66; model[3][7] = 8'h55;
        wr_idx = 3'd2; wr_data = 8'h88;
        pr_we = 1'b0;
        mem_addr = addr_of(2'd0, 3'd0); mem_wdata = 8'h99;
        @(negedge clk);
        wr_en = 1'b0; mem_we = 1'b0;
        model[3][2] = 8'h88; model[0][0] = 8'h99;
        rd_a_idx = 3'd4; rd_b_idx = 3'd7; #1;
        chk("R9", "byte beats pair and memory", 16'(rd_a_data), 16'h11);
        chk("R9", "pair beats memory", 16'(rd_b_data), 16'h55);
        sweep_mem("R9");
    endtask

    task automatic t_bank_timing;
        sel_bank(2'd1);
        bank_sel_we = 1'b1; bank_sel_val = 2'd3;
        wr_en = 1'b1; wr_idx = 3'd0; wr_data = 8'h9A;
        @(negedge clk);
        bank_sel_we = 1'b0; wr_en = 1'b0;
        model[1][0] = 8'h9A;
        mbank = 2'd3;
        chk("R2", "bank loaded", 16'(cur_bank), 16'd3);
        mem_addr = addr_of(2'd1, 3'd0); #1;
        chk("R2", "write used old bank", 16'(mem_rdata), 16'h9A);
        rd_a_idx = 3'd0; #1;
        chk("R2", "new bank X untouched", 16'(rd_a_data), 16'(model[3][0]));
        sweep_mem("R10");
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #800000;
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_fill_by_mem();
        t_byte_rw();
        t_pair();
        t_window();
        t_priority();
        t_bank_timing();
        finish_run();
    end
endmodule